// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects five interrupt sources for a small processor core and decides, at each instruction boundary, which one (if any) the core should service next. Four sources have fixed vector addresses. These are one non-maskable input and three maskable vectored inputs: a high input that is edge-latched, and a middle and a low input that are level-sensitive. The fifth source is a general request that is served through an external handshake. The controller pulls an active-low acknowledge. It then reads a restart opcode from the data bus and turns that opcode into a vector address.

Software controls the block through three inputs: a global-enable set strobe, a global-enable clear strobe, and an 8-bit configuration write. The configuration write can change the three masks, discard a latched high-input request, and drive a serial output bit. A status word is updated every cycle. It reports the masks, the global enable, the pending requests and a serial input bit. The core pulses `boundary_i` once per instruction boundary. One cycle later, `take_o` and `vec_o` give the selected vector.

Top module: `pvic_top`

## Requirements
- R1: After synchronous reset, `take_o`=0, `ext_ack_n_o`=1, `ser_out_o`=0, the global enable is off and all three masks are set. The first status word after reset is 0x07 when all inputs are low.
- R2: Priority, highest first, is: non-maskable, high vectored, middle vectored, low vectored, general request. At most one source is accepted per boundary.
- R3: A fixed-vector source accepted at a boundary gives `take_o`=1 for one cycle in the cycle after the boundary edge. `vec_o` is then 0x0024 for non-maskable, 0x003C for high, 0x0034 for middle and 0x002C for low.
- R4: The non-maskable input ignores the global enable and all masks. It is accepted only after a rising edge, and only if the line is still high at the boundary. It is not accepted again until the line has gone low and then high again.
- R5: A rising edge on the high input sets a pending flag whether or not that input is masked. The flag stays set until the high source is accepted, reset occurs, or a configuration write has bit 4 = 1.
- R6: The middle and low inputs are level-sensitive and have no latch. A pulse that has ended before the boundary is lost.
- R7: A configuration write with bit 3 = 1 loads the masks from the write word: bit 0 is low, bit 1 is middle, bit 2 is high, and 1 means disabled. With bit 3 = 0 the masks do not change.
- R8: A configuration write with bit 6 = 1 copies bit 7 to `ser_out_o` in the next cycle. With bit 6 = 0 the serial output is unchanged. Bits 6 and 7 have no effect on the masks.
- R9: `stat_o` is registered each cycle. Bits 2:0 are the masks, bit 3 is the global enable, bits 4, 5 and 6 are the pending low, middle and high requests, and bit 7 is `ser_in_i`.
- R10: `ien_set_i` turns the global enable on and `ien_clr_i` turns it off. Any accepted source turns it off. The three maskable sources and the general request are accepted only while the enable is on.
- R11: When the general request wins, `ext_ack_n_o` is low for exactly the next cycle and `ext_op_i` is sampled at the end of that cycle. If the sampled opcode has the form 11nnn111, `take_o`=1 follows with `vec_o` = n×8. Any other opcode yields no vector.
- R12: Sources are evaluated only on cycles where `boundary_i` is high, and never during the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| nmi_i | input | 1 | Non-maskable request line |
| irq_hi_i | input | 1 | High vectored request, edge-latched |
| irq_mid_i | input | 1 | Middle vectored request, level |
| irq_lo_i | input | 1 | Low vectored request, level |
| ext_req_i | input | 1 | General request served by external opcode |
| ext_ack_n_o | output | 1 | Active-low acknowledge for the general request |
| ext_op_i | input | 8 | Restart opcode returned on the data bus |
| ien_set_i | input | 1 | Global-enable set command |
| ien_clr_i | input | 1 | Global-enable clear command |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write word |
| ser_in_i | input | 1 | Serial input bit reported in status |
| ser_out_o | output | 1 | Serial output bit |
| stat_o | output | 8 | Status word |
| take_o | output | 1 | Vector valid pulse |
| vec_o | output | ADDR_W | Vector address |

## Verification
The hardest case to reach from the ports is the non-maskable re-arm rule. Only the history of the line decides whether a high level may be taken, so the bench has to create that history. Directed sequences do this: a second boundary while the line stays high, a low-then-high re-arm, and a rising edge that falls again before the boundary.

A similar ordering problem comes with the high-input latch. It must fill while the input is masked, survive until unmasked, and be discarded by a clear write. The bench reaches this with edges and writes placed in separate cycles.

Randomized rounds then mix input levels, mask writes and enable commands. Each round is checked against a priority model kept in the bench.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int VEC_W = 16;
  localparam int NSRC  = 5;

  // source index doubles as priority rank (higher index wins)
  typedef enum logic [2:0] {
    SRC_EXT = 3'd0,
    SRC_LO  = 3'd1,
    SRC_MID = 3'd2,
    SRC_HI  = 3'd3,
    SRC_NMI = 3'd4
  } src_e;

  function automatic logic [VEC_W-1:0] fixed_vec(input logic [NSRC-1:0] gnt);
    logic [VEC_W-1:0] v;
    v = '0;
    if (gnt[SRC_NMI])      v = VEC_W'(16'h0024);
    else if (gnt[SRC_HI])  v = VEC_W'(16'h003C);
    else if (gnt[SRC_MID]) v = VEC_W'(16'h0034);
    else if (gnt[SRC_LO])  v = VEC_W'(16'h002C);
    return v;
  endfunction
endpackage

// File: rtl/pvic_edge_latch.sv
module pvic_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= sig_i;
      if (clr_i)                pend_o <= 1'b0;
      else if (sig_i && !prev_q) pend_o <= 1'b1;
    end
  end

  // R5
  edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (sig_i && !prev_q && !clr_i) |=> pend_o);
endmodule

// File: rtl/pvic_prio_arb.sv
module pvic_prio_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_rank
    if (i == N-1) begin : g_top
      assign gnt_o[i] = req_i[i];
    end else begin : g_rest
      assign gnt_o[i] = req_i[i] & ~(|req_i[N-1:i+1]);
    end
  end
endmodule

// File: rtl/pvic_op_decode.sv
module pvic_op_decode #(
  parameter int ADDR_W = 16
) (
  input  logic [7:0]        op_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] vec_o
);
  assign ok_o  = (op_i[7:6] == 2'b11) && (op_i[2:0] == 3'b111);
  assign vec_o = {{(ADDR_W-6){1'b0}}, op_i[5:3], 3'b000};
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int ADDR_W = VEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic              nmi_i,
  input  logic              irq_hi_i,
  input  logic              irq_mid_i,
  input  logic              irq_lo_i,
  input  logic              ext_req_i,
  output logic              ext_ack_n_o,
  input  logic [7:0]        ext_op_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              ser_in_i,
  output logic              ser_out_o,
  output logic [7:0]        stat_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o
);
  logic             ien_q;
  logic [2:0]       mask_q;
  logic             ack_phase_q;
  logic             nmi_pend, hi_pend;
  logic             nmi_clr, hi_clr;
  logic [NSRC-1:0]  req, gnt;
  logic             eval, accept;
  logic             op_ok;
  logic [ADDR_W-1:0] op_vec, tab_vec;
  logic             unused_cfg_bit;

  assign unused_cfg_bit = cfg_wdata_i[5];

  assign eval   = boundary_i && !ack_phase_q;
  assign accept = eval && (|gnt);

  assign req[SRC_NMI] = nmi_pend & nmi_i;
  assign req[SRC_HI]  = hi_pend   & ~mask_q[2] & ien_q;
  assign req[SRC_MID] = irq_mid_i & ~mask_q[1] & ien_q;
  assign req[SRC_LO]  = irq_lo_i  & ~mask_q[0] & ien_q;
  assign req[SRC_EXT] = ext_req_i & ien_q;

  assign nmi_clr = eval && gnt[SRC_NMI];
  assign hi_clr  = (eval && gnt[SRC_HI]) || (cfg_we_i && cfg_wdata_i[4]);

  pvic_edge_latch u_nmi_latch (
    .clk(clk), .rst(rst), .sig_i(nmi_i), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  pvic_edge_latch u_hi_latch (
    .clk(clk), .rst(rst), .sig_i(irq_hi_i), .clr_i(hi_clr), .pend_o(hi_pend)
  );

  pvic_prio_arb #(.N(NSRC)) u_arb (
    .req_i(req), .gnt_o(gnt)
  );

  pvic_op_decode #(.ADDR_W(ADDR_W)) u_dec (
    .op_i(ext_op_i), .ok_o(op_ok), .vec_o(op_vec)
  );

  assign tab_vec = ADDR_W'(fixed_vec(gnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q       <= 1'b0;
      mask_q      <= 3'b111;
      ser_out_o   <= 1'b0;
      ack_phase_q <= 1'b0;
      ext_ack_n_o <= 1'b1;
      take_o      <= 1'b0;
      vec_o       <= '0;
      stat_o      <= 8'h07;
    end else begin
      take_o      <= 1'b0;
      ext_ack_n_o <= 1'b1;
      ack_phase_q <= 1'b0;

      if (ien_set_i)      ien_q <= 1'b1;
      else if (ien_clr_i) ien_q <= 1'b0;
      if (accept)         ien_q <= 1'b0;

      if (cfg_we_i && cfg_wdata_i[3]) mask_q    <= cfg_wdata_i[2:0];
      if (cfg_we_i && cfg_wdata_i[6]) ser_out_o <= cfg_wdata_i[7];

      if (ack_phase_q) begin
        if (op_ok) begin
          take_o <= 1'b1;
          vec_o  <= op_vec;
        end
      end else if (accept) begin
        if (gnt[SRC_EXT]) begin
          ack_phase_q <= 1'b1;
          ext_ack_n_o <= 1'b0;
        end else begin
          take_o <= 1'b1;
          vec_o  <= tab_vec;
        end
      end

      stat_o <= {ser_in_i, hi_pend, irq_mid_i, irq_lo_i, ien_q, mask_q};
    end
  end

  // R2
  one_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R11
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_ack_n_o |-> !take_o);

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_ack_n_o |=> ext_ack_n_o);

  // R10
  ien_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_ack_n_o) |-> !ien_q);

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && !cfg_wdata_i[3]) |=> $stable(mask_q));

  // R5
  hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && cfg_wdata_i[4]) |=> !hi_pend);

  // R4
  nmi_level_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o == ADDR_W'(16'h0024)) |-> $past(nmi_i));

  // R12
  take_origin_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ($past(boundary_i) || $past(ack_phase_q)));
endmodule

// File: tb/pvic_top_bench.sv
module pvic_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary = 0, nmi = 0, hi = 0, mid = 0, lo = 0, ext_req = 0;
  logic [7:0] ext_op = 8'h00;
  logic ien_set = 0, ien_clr = 0, cfg_we = 0, ser_in = 0;
  logic [7:0] cfg_wd = 8'h00;
  logic ext_ack_n, ser_out, take;
  logic [7:0] stat;
  logic [AW-1:0] vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvic_top #(.ADDR_W(AW)) u_pvic_top (
    .clk(clk), .rst(rst), .boundary_i(boundary), .nmi_i(nmi),
    .irq_hi_i(hi), .irq_mid_i(mid), .irq_lo_i(lo), .ext_req_i(ext_req),
    .ext_ack_n_o(ext_ack_n), .ext_op_i(ext_op), .ien_set_i(ien_set),
    .ien_clr_i(ien_clr), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .ser_in_i(ser_in), .ser_out_o(ser_out), .stat_o(stat),
    .take_o(take), .vec_o(vec)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] w);
    cfg_we = 1; cfg_wd = w; step(); cfg_we = 0;
  endtask

  task automatic ien_on();
    ien_set = 1; step(); ien_set = 0;
  endtask

  task automatic bnd();
    boundary = 1; step(); boundary = 0;
  endtask

  // priority model: returns {take, vector}
  function automatic logic [16:0] ref_pick(input logic hp, input logic m, input logic l,
                                           input logic [2:0] msk, input logic en);
    if (en && hp && !msk[2]) return {1'b1, 16'h003C};
    if (en && m  && !msk[1]) return {1'b1, 16'h0034};
    if (en && l  && !msk[0]) return {1'b1, 16'h002C};
    return 17'h0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] m_mask;
    logic m_ien, m_hi_p, m_hi_lvl, m_ser;
    logic [16:0] e;
    void'($urandom(32'h5EED_0042));

    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 take", take, 0);
    chk("R1 ack", ext_ack_n, 1);
    chk("R1 serout", ser_out, 0);
    chk("R1 stat", stat, 8'h07);

    // R7 mask load with gate bit, 1 = disabled
    wr(8'h0D); step();
    chk("R7 mask load", stat[3:0], 4'h5);
    wr(8'h02); step();
    chk("R7 mask gated", stat[2:0], 3'h5);

    // R10 enable commands
    ien_on(); step();
    chk("R10 ien set", stat[3], 1);
    ien_clr = 1; step(); ien_clr = 0; step();
    chk("R10 ien clr", stat[3], 0);

    // R6 level inputs
    wr(8'h08); ien_on();
    lo = 1; step(); lo = 0; bnd();
    chk("R6 lost pulse", take, 0);
    lo = 1; bnd();
    chk("R6 level take", take, 1);
    chk("R3 low vector", vec, 16'h002C);
    lo = 0; step();
    chk("R10 ien cleared on accept", stat[3], 0);
    lo = 1; bnd();
    chk("R10 gated by ien", take, 0);
    lo = 0;

    // R2 priority
    mid = 1; lo = 1; ien_on(); bnd();
    chk("R2 mid over low", vec, 16'h0034);
    ien_on(); hi = 1; step(); bnd();
    chk("R2 high over mid", vec, 16'h003C);
    chk("R3 high take", take, 1);
    hi = 0; mid = 0; lo = 0;

    // R5 high latch
    wr(8'h0C); ien_on();
    hi = 1; step(); hi = 0; step();
    chk("R5 pending while masked", stat[6], 1);
    bnd();
    chk("R5 masked no take", take, 0);
    wr(8'h08); bnd();
    chk("R5 latched take", vec, 16'h003C);
    step(); step();
    chk("R5 cleared by accept", stat[6], 0);
    hi = 1; step(); hi = 0; wr(8'h10); step();
    chk("R5 cleared by write", stat[6], 0);

    // R4 non-maskable
    wr(8'h0F);
    nmi = 1; step(); bnd();
    chk("R4 nmi take", take, 1);
    chk("R3 nmi vector", vec, 16'h0024);
    bnd();
    chk("R4 no retake while high", take, 0);
    nmi = 0; step(); nmi = 1; step(); bnd();
    chk("R4 rearm", vec, 16'h0024);
    nmi = 0; step(); nmi = 1; step(); nmi = 0; step(); bnd();
    chk("R4 dropped before boundary", take, 0);

    // R8 serial output, R9 serial input
    wr(8'hC0);
    chk("R8 ser out set", ser_out, 1);
    step(); step();
    chk("R8 masks untouched", stat[2:0], 3'h7);
    wr(8'h80);
    chk("R8 no enable keeps", ser_out, 1);
    wr(8'h40);
    chk("R8 ser out clear", ser_out, 0);
    ser_in = 1; step(); step();
    chk("R9 ser in", stat[7], 1);
    ser_in = 0;

    // R11 external request
    wr(8'h08); ien_on(); ext_req = 1; bnd();
    chk("R11 ack low", ext_ack_n, 0);
    chk("R11 no take in ack", take, 0);
    ext_op = 8'hEF; step();
    chk("R11 decoded take", take, 1);
    chk("R11 decoded vector", vec, 16'h0028);
    chk("R11 ack released", ext_ack_n, 1);
    ien_on(); bnd(); ext_op = 8'h3E; step();
    chk("R11 bad opcode", take, 0);
    bnd();
    chk("R11 needs ien", ext_ack_n, 1);

    // R2 nmi beats external
    ien_on(); nmi = 1; step(); bnd();
    chk("R2 nmi over ext", vec, 16'h0024);
    chk("R2 no ack", ext_ack_n, 1);
    ext_req = 0; nmi = 0;

    // R12 boundary needed
    ien_on(); lo = 1; step(); step();
    chk("R12 no boundary", take, 0);
    bnd();
    chk("R12 boundary take", vec, 16'h002C);
    lo = 0;

    // random rounds
    wr(8'h1F);
    ien_clr = 1; step(); ien_clr = 0;
    m_mask = 3'h7; m_ien = 0; m_hi_p = 0; m_hi_lvl = 0; m_ser = 0;
    for (int it = 0; it < 300; it++) begin
      logic nh;
      nh = 1'($urandom);
      mid = 1'($urandom); lo = 1'($urandom);
      if (nh && !m_hi_lvl) m_hi_p = 1;
      hi = nh; m_hi_lvl = nh;
      step();
      if ($urandom % 3 == 0) begin
        logic [7:0] w;
        w = 8'($urandom);
        if (w[3]) m_mask = w[2:0];
        if (w[4]) m_hi_p = 0;
        if (w[6]) m_ser = w[7];
        wr(w);
      end
      if ($urandom % 2 == 0) begin
        m_ien = 1;
        ien_on();
      end
      e = ref_pick(m_hi_p, mid, lo, m_mask, m_ien);
      bnd();
      chk("R2 random take", take, e[16]);
      if (e[16]) chk("R3 random vector", vec, e[15:0]);
      chk("R9 random status", stat, {1'b0, m_hi_p, mid, lo, m_ien, m_mask});
      chk("R8 random serial", ser_out, m_ser);
      if (e[16]) begin
        m_ien = 0;
        if (e[15:0] == 16'h003C) m_hi_p = 0;
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule